// File: doc/BRIEF.md
# Synchronous 36-bit FIFO with Reset Filtering and Retransmit

This block is a single-clock first-in first-out buffer for 36-bit words. Its control section recognises three long-pulse commands: a master reset, a partial reset and a retransmit. A command only counts once its active-low input has been held low for a minimum number of rising clock edges. The partial reset and the retransmit share one active-low pin. A select input decides which of the two that pin performs.

Master reset empties the buffer. On its release edge it captures a 3-bit offset select, which sets the threshold of the almost-empty and almost-full flags. On the following edge it captures a mode input, which picks one of two read timings:

- In standard timing, a read strobe moves the head word to the output one cycle later.
- In fall-through timing, the head word is presented with output-ready as soon as it is available.

Partial reset empties the buffer but keeps the captured offset and timing. Retransmit rewinds only the read side to memory location 0, so the data written since the last reset can be read again. This works as long as no more than the memory depth of words has been written since that reset.

Top module: `fifo36_rt_ctrl`

## Requirements
- R1: Words leave the buffer in the order they were written.
- R2: A command input acts only after it has been sampled low on 4 consecutive rising edges (HOLD). A shorter low pulse changes neither the contents nor the flags.
- R3: Master reset and partial reset return both pointers to location 0, which leaves the buffer empty.
- R4: While a master or partial reset is in effect, in_rdy and out_rdy are 0, ae_n is 0 and af_n is 1.
- R5: in_rdy rises on the second rising edge after the release edge. The release edge is the first edge that samples the input high. Writes are accepted only while in_rdy is 1.
- R6: Offsets are set as follows:
  - ofs_sel is captured on the master-reset release edge.
  - The select values 0 to 7 map to offsets 8, 16, 64, 256, 512, 1024, 2048 and 4096, each clamped to depth-1.
  - ae_n is 0 while occupancy is at most the offset.
  - af_n is 0 while free memory locations are at most the offset.
  - In fall-through timing, occupancy includes the presented word.
- R7: Timing is selected as follows:
  - timing_in is captured on the edge after the master-reset release edge. 1 selects standard timing and 0 selects fall-through timing.
  - In standard timing, out_rdy is 1 whenever memory holds a word, and rd_data changes only on the edge of a read strobe.
  - In fall-through timing, out_rdy is 1 with the head word already on rd_data, and a strobe advances to the next word.
- R8: Partial reset keeps the captured offset and timing.
- R9: The shared pin cmd_n acts as partial reset if cmd_sel is 0, and as retransmit if cmd_sel is 1. cmd_sel is sampled on the 4th low edge.
- R10: Retransmit behaves as follows:
  - It moves only the read pointer to location 0. The write pointer and the stored data stay as they were.
  - out_rdy is 0 while the retransmit is held.
  - After release, reading restarts from location 0.
- R11: A write while in_rdy is 0 and a read while the buffer is empty are ignored and move no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| mrst_n | input | 1 | Master reset, active low, long pulse |
| cmd_n | input | 1 | Shared partial-reset / retransmit command, active low |
| cmd_sel | input | 1 | 0 = cmd_n is partial reset, 1 = retransmit |
| timing_in | input | 1 | Timing choice captured after master reset (1 standard, 0 fall-through) |
| ofs_sel | input | 3 | Flag offset select captured at master-reset release |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 36 | Write word |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 36 | Read word |
| in_rdy | output | 1 | Ready for writes (not full, not in reset) |
| out_rdy | output | 1 | Data available / word presented |
| ae_n | output | 1 | Almost empty, active low |
| af_n | output | 1 | Almost full, active low |

## Verification
The data path is driven with the following patterns:
- A ten-word burst in fall-through timing. It separates correct ordering and the fall-through presentation from off-by-one loading, and it crosses the almost-empty threshold.
- A full-depth fill and drain in standard timing, with an extra write and an extra read at the ends. These show the full and empty boundaries and the almost-full threshold, and they show that rejected strobes leave the pointers where they were.
- A partially read buffer that is then retransmitted. It tells a rewind to location 0 apart from a full clear.
- A short reset pulse and a partial reset given after the select input has changed. Together they separate the pulse filter and the kept configuration from a design that re-samples its configuration inputs.

// File: rtl/fifo36_rt_ctrl.sv
module fifo36_rt_ctrl #(
  parameter int DW   = 36,
  parameter int AW   = 6,
  parameter int HOLD = 4
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          cmd_n,
  input  logic          cmd_sel,
  input  logic          timing_in,
  input  logic [2:0]    ofs_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          in_rdy,
  output logic          out_rdy,
  output logic          ae_n,
  output logic          af_n
);
  localparam int DEPTH = 1 << AW;
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [AW:0] FULLV = (AW+1)'(DEPTH);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wr_ptr, rd_ptr, count, occ;
  logic [CW-1:0] mcnt, scnt;
  logic          m_act, p_act, rt_act, run, mode_q, mode_pend, ov;
  logic [1:0]    wake;
  logic [2:0]    fs_q;
  int unsigned   off;

  function automatic int unsigned off_of(input logic [2:0] s);
    int unsigned v;
    case (s)
      3'd0: v = 8;
      3'd1: v = 16;
      3'd2: v = 64;
      default: v = 32'd1 << (int'(s) + 5);
    endcase
    if (v > DEPTH - 1) v = DEPTH - 1;
    return v;
  endfunction

  wire m_hit = !mrst_n && mcnt == LAST && !m_act;
  wire m_rel = mrst_n && m_act;
  wire s_hit = !cmd_n && scnt == LAST && !p_act && !rt_act && !m_act && !m_hit;
  wire p_hit = s_hit && !cmd_sel;
  wire t_hit = s_hit && cmd_sel;
  wire s_rel = cmd_n && (p_act || rt_act);
  wire fwft  = !mode_q;
  wire clr   = m_hit || p_hit;

  assign count   = wr_ptr - rd_ptr;
  assign occ     = count + {{AW{1'b0}}, ov & fwft};
  assign off     = off_of(fs_q);
  assign in_rdy  = run && count != FULLV;
  assign out_rdy = !rt_act && (fwft ? ov : count != '0);
  assign ae_n    = 32'(occ) > off;
  assign af_n    = 32'(FULLV - count) > off;

  wire do_wr = wr_en && in_rdy;

  always_ff @(posedge clk) begin
    mcnt <= mrst_n ? '0 : (mcnt == LAST ? mcnt : mcnt + 1'b1);
    scnt <= cmd_n  ? '0 : (scnt == LAST ? scnt : scnt + 1'b1);
  end

  always_ff @(posedge clk) begin
    if (m_hit) begin
      m_act  <= 1'b1;
      p_act  <= 1'b0;
      rt_act <= 1'b0;
      run    <= 1'b0;
      wake   <= 2'd0;
    end else if (m_act) begin
      if (m_rel) begin
        m_act     <= 1'b0;
        fs_q      <= ofs_sel;
        mode_pend <= 1'b1;
        wake      <= 2'd1;
      end
    end else begin
      if (p_hit) begin
        p_act <= 1'b1;
        run   <= 1'b0;
        wake  <= 2'd0;
      end else if (t_hit) begin
        rt_act <= 1'b1;
      end else if (s_rel) begin
        if (p_act) wake <= 2'd1;
        p_act  <= 1'b0;
        rt_act <= 1'b0;
      end
      if (!p_hit) begin
        if (wake == 2'd1) begin
          wake <= 2'd2;
          if (mode_pend) begin
            mode_q    <= timing_in;
            mode_pend <= 1'b0;
          end
        end else if (wake == 2'd2) begin
          wake <= 2'd0;
          run  <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk)
    if (do_wr && !clr) mem[wr_ptr[AW-1:0]] <= wr_data;

  always_ff @(posedge clk) begin
    if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      ov     <= 1'b0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + 1'b1;
      if (t_hit) begin
        rd_ptr <= '0;
        ov     <= 1'b0;
      end else if (!rt_act) begin
        if (!fwft) begin
          if (rd_en && count != '0) begin
            rd_data <= mem[rd_ptr[AW-1:0]];
            rd_ptr  <= rd_ptr + 1'b1;
          end
        end else if (count != '0 && (!ov || rd_en)) begin
          rd_data <= mem[rd_ptr[AW-1:0]];
          rd_ptr  <= rd_ptr + 1'b1;
          ov      <= 1'b1;
        end else if (rd_en) begin
          ov <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/fifo36_rt_ctrl_chk.sv
module fifo36_rt_ctrl_chk #(
  parameter int AW = 6
) (
  input logic        clk,
  input logic        m_act,
  input logic        p_act,
  input logic        rt_act,
  input logic        m_hit,
  input logic        p_hit,
  input logic        wr_en,
  input logic        in_rdy,
  input logic        out_rdy,
  input logic        ae_n,
  input logic        af_n,
  input logic        mode_q,
  input logic [2:0]  fs_q,
  input logic [AW:0] wr_ptr,
  input logic [AW:0] rd_ptr
);
  localparam logic [AW:0] FULLV = (AW+1)'(1 << AW);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (m_act) armed <= 1'b1;

  assert_reset_flags_R4: assert property (@(posedge clk) disable iff (!armed)
    (m_act || p_act) |-> (!in_rdy && !out_rdy && !ae_n && af_n));

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!armed)
    (wr_ptr - rd_ptr) <= FULLV);

  assert_full_write_ignored_R11: assert property (@(posedge clk) disable iff (!armed)
    (wr_en && !in_rdy && !m_hit && !p_hit) |=> $stable(wr_ptr));

  assert_rewind_R10: assert property (@(posedge clk) disable iff (!armed)
    rt_act |-> (rd_ptr == '0 && !out_rdy));

  assert_partial_keeps_R8: assert property (@(posedge clk) disable iff (!armed)
    p_act |=> ($stable(fs_q) && $stable(mode_q)));
endmodule

bind fifo36_rt_ctrl fifo36_rt_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .m_act(m_act), .p_act(p_act), .rt_act(rt_act),
  .m_hit(m_hit), .p_hit(p_hit), .wr_en(wr_en), .in_rdy(in_rdy),
  .out_rdy(out_rdy), .ae_n(ae_n), .af_n(af_n), .mode_q(mode_q),
  .fs_q(fs_q), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/test_fifo36_rt_ctrl.sv
module test_fifo36_rt_ctrl;
  logic clk = 0, mrst_n = 1, cmd_n = 1, cmd_sel = 0, timing_in = 0;
  logic [2:0] ofs_sel = 0;
  logic wr_en = 0, rd_en = 0;
  logic [35:0] wr_data = 0, rd_data, prev;
  logic in_rdy, out_rdy, ae_n, af_n;
  int total = 0, bad = 0;

  fifo36_rt_ctrl i_fifo36_rt_ctrl (.*);

  always #4 clk = ~clk;

  localparam logic [36:0] VEC [10] = '{
    {36'h0_1111_0001, 1'b0}, {36'h8_2222_0002, 1'b0}, {36'h0_3333_0003, 1'b0},
    {36'hF_4444_0004, 1'b0}, {36'h0_5555_0005, 1'b0}, {36'h7_6666_0006, 1'b0},
    {36'h0_7777_0007, 1'b0}, {36'hA_8888_0008, 1'b0}, {36'h0_9999_0009, 1'b1},
    {36'h5_AAAA_000A, 1'b1}};

  task automatic step; @(negedge clk); endtask

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [35:0] d);
    wr_en = 1; wr_data = d; step; wr_en = 0;
  endtask

  task automatic strobe;
    rd_en = 1; step; rd_en = 0;
  endtask

  task automatic master(input logic [2:0] fs, input logic std);
    mrst_n = 0;
    repeat (4) step;
    chk("R4 in_rdy", in_rdy, 0); chk("R4 out_rdy", out_rdy, 0);
    chk("R4 ae_n", ae_n, 0);     chk("R4 af_n", af_n, 1);
    ofs_sel = fs; timing_in = std; mrst_n = 1;
    step;
    ofs_sel = ~fs;
    step;
    chk("R5 in_rdy one edge after release", in_rdy, 0);
    timing_in = ~std;
    step;
    chk("R5 in_rdy two edges after release", in_rdy, 1);
    chk("R3 empty after master", out_rdy, 0);
  endtask

  initial begin
    step;
    // fall-through timing, offset 8: vector walk
    master(3'd0, 1'b0);
    foreach (VEC[i]) begin
      push(VEC[i][36:1]);
      chk("R6 ae_n vs occupancy", ae_n, VEC[i][0]);
    end
    step;
    chk("R7 fall-through ready", out_rdy, 1);
    foreach (VEC[i]) begin
      chk("R1 order", rd_data, VEC[i][36:1]);
      strobe;
    end
    chk("R7 ready drops when drained", out_rdy, 0);

    // short master pulse ignored
    push(36'h1_2345_6789); step;
    mrst_n = 0; repeat (3) step; mrst_n = 1; step;
    chk("R2 short pulse keeps ready", out_rdy, 1);
    chk("R2 short pulse keeps data", rd_data, 36'h1_2345_6789);

    // retransmit in fall-through timing
    master(3'd0, 1'b0);
    for (int k = 0; k < 4; k++) push(36'h2_0000_0000 + 36'(k));
    step;
    for (int k = 0; k < 2; k++) begin
      chk("R1 pre-rewind", rd_data, 36'h2_0000_0000 + 36'(k));
      strobe;
    end
    cmd_sel = 1; cmd_n = 0;
    repeat (4) step;
    chk("R10 out_rdy held low", out_rdy, 0);
    chk("R9 retransmit is not a reset", in_rdy, 1);
    cmd_n = 1; step; step;
    chk("R10 ready after rewind", out_rdy, 1);
    for (int k = 0; k < 4; k++) begin
      chk("R10 replay from location 0", rd_data, 36'h2_0000_0000 + 36'(k));
      strobe;
    end
    chk("R10 write pointer kept", out_rdy, 0);

    // standard timing, offset select 2 (clamped to 63), then partial reset
    master(3'd2, 1'b1);
    prev = rd_data;
    push(36'h3_0000_0001); step;
    chk("R7 standard ready", out_rdy, 1);
    chk("R7 standard no fall-through", rd_data, prev);
    strobe;
    chk("R7 standard data after strobe", rd_data, 36'h3_0000_0001);
    for (int k = 0; k < 10; k++) push(36'h3_1000_0000 + 36'(k));
    chk("R6 clamped offset latched", ae_n, 0);
    ofs_sel = 3'd0; cmd_sel = 0; cmd_n = 0;
    repeat (4) step;
    chk("R4 partial in_rdy", in_rdy, 0); chk("R4 partial out_rdy", out_rdy, 0);
    chk("R4 partial ae_n", ae_n, 0);     chk("R4 partial af_n", af_n, 1);
    cmd_n = 1; step; step;
    chk("R5 partial in_rdy one edge", in_rdy, 0);
    step;
    chk("R5 partial in_rdy two edges", in_rdy, 1);
    chk("R3 partial empties (R9 select low)", out_rdy, 0);
    prev = rd_data;
    for (int k = 0; k < 10; k++) push(36'h4_0000_0000 + 36'(k));
    chk("R8 offset kept", ae_n, 0);
    chk("R8 timing kept", rd_data, prev);
    strobe;
    chk("R3 first word after partial", rd_data, 36'h4_0000_0000);

    // standard timing, offset 8: full and empty boundaries
    master(3'd0, 1'b1);
    for (int k = 0; k < 64; k++) begin
      push(36'h100 + 36'(k));
      if (k == 7)  chk("R6 ae_n at 8", ae_n, 0);
      if (k == 8)  chk("R6 ae_n at 9", ae_n, 1);
      if (k == 54) chk("R6 af_n at 55", af_n, 1);
      if (k == 55) chk("R6 af_n at 56", af_n, 0);
    end
    chk("R11 full", in_rdy, 0);
    push(36'hDEAD);
    for (int k = 0; k < 64; k++) begin
      strobe;
      if (rd_data !== 36'h100 + 36'(k)) chk("R11 drain after ignored write", rd_data, 36'h100 + 36'(k));
    end
    chk("R11 last word", rd_data, 36'h13F);
    chk("R11 empty after drain", out_rdy, 0);
    strobe;
    chk("R11 empty read ignored", rd_data, 36'h13F);
    push(36'hABC); strobe;
    chk("R11 pointer unmoved by empty read", rd_data, 36'hABC);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule